// File: doc/BRIEF.md
# Cascaded Two-Level Interrupt Controller

This block collects device interrupt lines for a workstation-class processor and presents them as two CPU request lines. Each request line belongs to a primary group of eight status bits, and each group has its own mask register. An extra group of eight mappable lines does not drive the CPU directly. It is filtered by two independent map masks. Each filtered result collapses to one bit that occupies a fixed slot in a primary group, so software sees a 32-entry interrupt number space: 0 to 7 primary group 0, 8 to 15 primary group 1, 16 to 23 mappable lines through map mask 0, and 24 to 31 mappable lines through map mask 1.

Two timer outputs are caught as latched flags on their rising edges. Software acknowledges them through a write-only clear register. Every other source is level-sensitive and is shown live. All registers sit on a simple word-addressed bus. Reads are combinational. A write takes effect at the clock edge where the write enable is high. Write data is 8 bits wide because no register holds more. The read data is 32 bits wide, and its upper 24 bits are always zero.

Top module: `cascade_irq_ctrl`

## Requirements
- R1: A synchronous active-high reset clears all four mask registers and both timer flags, and drives both request lines low. A timer line that is already high when reset is released does not set its flag.
- R2: Each of the four mask registers reads back the last 8-bit value written to it, and it is unchanged in cycles without a write to its address.
- R3: Status reads show the current input levels. A write to a status address changes no register. Status of group 0 is at byte 0x00, status of group 1 at 0x08, and mappable status at 0x10.
- R4: Bit 7 of the group-0 status is the OR over the mappable lines ANDed with map mask 0. Bits 6..0 of the group-0 status are `l0_line[6:0]`.
- R5: Bit 3 of the group-1 status is the OR over the mappable lines ANDed with map mask 1. Bits 0 and 1 of the group-1 status are the timer-0 and timer-1 flags. Bit 2 is `l1_line[0]`, and bits 7..4 are `l1_line[4:1]`.
- R6: `irq_l0` and `irq_l1` each equal the OR of the group's status ANDed with the group's mask, taken one clock edge later.
- R7: A timer flag is set at the edge where its `tmr_line` bit was low at the previous edge and is high now. A line that stays high does not set the flag again after it has been cleared.
- R8: A write to byte address 0x1C clears timer flag 0 if data bit 0 is 1, and clears timer flag 1 if data bit 1 is 1. A rising edge in the same cycle wins over the clear.
- R9: The mask registers are at 0x04 (group 0), 0x0C (group 1), 0x14 (map mask 0) and 0x18 (map mask 1, one word above map mask 0). Address 0x1C and every other address read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 5 | Byte address of the register |
| bus_wen | input | 1 | Write enable for this cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| l0_line | input | 7 | Level-sensitive sources for group-0 bits 6..0 |
| l1_line | input | 5 | Level-sensitive sources for group-1 bits 2, 4..7 |
| map_line | input | 8 | Level-sensitive mappable sources |
| tmr_line | input | 2 | Timer outputs, caught on their rising edges |
| irq_l0 | output | 1 | Registered CPU request for group 0 |
| irq_l1 | output | 1 | Registered CPU request for group 1 |

## Verification
Every cycle, the assertions check the timing relations that do not depend on history beyond one edge. They check that mask registers hold or load correctly, that a pending masked bit raises its request one edge later and a quiet group drops it, that a masked cascade reaches the CPU through the reserved bit, and that timer edges set flags and clears remove them. Some behaviour can only be shown by the bench's scenarios against its behavioural model: the full address decode, read-back of every register, status writes being ignored, a clear colliding with a new edge, and a high timer line at reset release leaving its flag clear.

// File: rtl/cirq_pkg.sv
package cirq_pkg;
    localparam int DATA_W = 32;
    localparam int SRC_W  = 8;
    localparam int ADDR_W = 5;
    localparam int TMR_N  = 2;

    localparam logic [ADDR_W-1:0] OFF_L0_STAT  = 5'h00;
    localparam logic [ADDR_W-1:0] OFF_L0_MASK  = 5'h04;
    localparam logic [ADDR_W-1:0] OFF_L1_STAT  = 5'h08;
    localparam logic [ADDR_W-1:0] OFF_L1_MASK  = 5'h0C;
    localparam logic [ADDR_W-1:0] OFF_MAP_STAT = 5'h10;
    localparam logic [ADDR_W-1:0] OFF_MAP_MSK0 = 5'h14;
    localparam logic [ADDR_W-1:0] OFF_MAP_MSK1 = OFF_MAP_MSK0 + 5'h04;
    localparam logic [ADDR_W-1:0] OFF_TMR_CLR  = 5'h1C;

    typedef struct packed {
        logic irq0;
        logic irq1;
    } req_state_t;
endpackage

// File: rtl/cirq_mask_reg.sv
module cirq_mask_reg #(
    parameter int W = cirq_pkg::SRC_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic [W-1:0] status,
    output logic [W-1:0] mask,
    output logic         pending
);
    typedef struct packed {
        logic [W-1:0] mask;
    } msk_state_t;

    msk_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) st_d.mask = wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign mask    = st_q.mask;
    assign pending = |(status & st_q.mask);

    // R2: mask keeps its value without a write, loads the written value with one
    a_r2_mask_hold: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(mask));
    a_r2_mask_load: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> mask == $past(wr_data));
endmodule

// File: rtl/cirq_timer_flags.sv
module cirq_timer_flags #(
    parameter int N = cirq_pkg::TMR_N
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] tmr_in,
    input  logic         clr_en,
    input  logic [N-1:0] clr_bits,
    output logic [N-1:0] flags
);
    typedef struct packed {
        logic [N-1:0] prev;
        logic [N-1:0] flag;
    } tmr_state_t;

    tmr_state_t st_d, st_q;
    logic [N-1:0] clr_vec;

    always_comb begin
        clr_vec   = clr_en ? clr_bits : '0;
        st_d.prev = tmr_in;
        st_d.flag = (st_q.flag & ~clr_vec) | (tmr_in & ~st_q.prev);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.prev <= tmr_in;
            st_q.flag <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flags = st_q.flag;

    for (genvar i = 0; i < N; i++) begin : g_chk
        // R7: a rising timer edge sets its flag
        a_r7_edge_sets: assert property (@(posedge clk) disable iff (rst)
            $rose(tmr_in[i]) |-> ##0 1'b1 ##1 flags[i]);
        // R8: a clear without a colliding edge empties the flag
        a_r8_clear_wins: assert property (@(posedge clk) disable iff (rst)
            (clr_en && clr_bits[i] && !$rose(tmr_in[i])) |=> !flags[i]);
    end
endmodule

// File: rtl/cascade_irq_ctrl.sv
module cascade_irq_ctrl #(
    parameter int ADDR_W = cirq_pkg::ADDR_W,
    parameter int DATA_W = cirq_pkg::DATA_W,
    parameter int SRC_W  = cirq_pkg::SRC_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wen,
    input  logic [SRC_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [SRC_W-2:0]  l0_line,
    input  logic [SRC_W-4:0]  l1_line,
    input  logic [SRC_W-1:0]  map_line,
    input  logic [1:0]        tmr_line,
    output logic              irq_l0,
    output logic              irq_l1
);
    import cirq_pkg::*;

    localparam int L1_N = SRC_W - 3;
    localparam int PADW = DATA_W - SRC_W;

    logic [SRC_W-1:0] l0_stat, l1_stat, l0_mask, l1_mask;
    logic [SRC_W-1:0] map_mask [2];
    logic [1:0]       casc;
    logic [1:0]       tflag;
    logic             l0_pend, l1_pend;
    logic [SRC_W-1:0] rd8;
    logic             tclr_en;

    // mappable cascade: two map masks over the same mappable status
    for (genvar m = 0; m < 2; m++) begin : g_map
        localparam logic [ADDR_W-1:0] MOFF = OFF_MAP_MSK0 + ADDR_W'(4 * m);
        cirq_mask_reg #(.W(SRC_W)) i_map_mask (
            .clk     (clk),
            .rst     (rst),
            .wr_en   (bus_wen && bus_addr == MOFF),
            .wr_data (bus_wdata),
            .status  (map_line),
            .mask    (map_mask[m]),
            .pending (casc[m])
        );
    end

    assign l0_stat = {casc[0], l0_line};
    assign l1_stat = {l1_line[L1_N-1:1], casc[1], l1_line[0], tflag};

    cirq_mask_reg #(.W(SRC_W)) i_l0_mask (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (bus_wen && bus_addr == OFF_L0_MASK),
        .wr_data (bus_wdata),
        .status  (l0_stat),
        .mask    (l0_mask),
        .pending (l0_pend)
    );

    cirq_mask_reg #(.W(SRC_W)) i_l1_mask (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (bus_wen && bus_addr == OFF_L1_MASK),
        .wr_data (bus_wdata),
        .status  (l1_stat),
        .mask    (l1_mask),
        .pending (l1_pend)
    );

    assign tclr_en = bus_wen && bus_addr == OFF_TMR_CLR;

    cirq_timer_flags #(.N(2)) i_tmr (
        .clk      (clk),
        .rst      (rst),
        .tmr_in   (tmr_line),
        .clr_en   (tclr_en),
        .clr_bits (bus_wdata[1:0]),
        .flags    (tflag)
    );

    // request registers, two-process
    req_state_t req_d, req_q;

    always_comb begin
        req_d.irq0 = l0_pend;
        req_d.irq1 = l1_pend;
    end

    always_ff @(posedge clk) begin
        if (rst) req_q <= '0;
        else     req_q <= req_d;
    end

    assign irq_l0 = req_q.irq0;
    assign irq_l1 = req_q.irq1;

    // read decode
    always_comb begin
        case (bus_addr)
            OFF_L0_STAT:  rd8 = l0_stat;
            OFF_L0_MASK:  rd8 = l0_mask;
            OFF_L1_STAT:  rd8 = l1_stat;
            OFF_L1_MASK:  rd8 = l1_mask;
            OFF_MAP_STAT: rd8 = map_line;
            OFF_MAP_MSK0: rd8 = map_mask[0];
            OFF_MAP_MSK1: rd8 = map_mask[1];
            default:      rd8 = '0;
        endcase
    end

    assign bus_rdata = {{PADW{1'b0}}, rd8};

    // R6: request follows masked status one edge later
    a_r6_irq0_rise: assert property (@(posedge clk) disable iff (rst)
        l0_pend |=> irq_l0);
    a_r6_irq1_fall: assert property (@(posedge clk) disable iff (rst)
        !l1_pend |=> !irq_l1);
    a_r6_irq0_needs_mask: assert property (@(posedge clk) disable iff (rst)
        (l0_mask == '0) |=> !irq_l0);
    // R4: a masked mappable line reaches the CPU through group-0 bit 7
    a_r4_casc0_path: assert property (@(posedge clk) disable iff (rst)
        (|(map_line & map_mask[0]) && l0_mask[7]) |=> irq_l0);
    // R5: a masked mappable line reaches the CPU through group-1 bit 3
    a_r5_casc1_path: assert property (@(posedge clk) disable iff (rst)
        (|(map_line & map_mask[1]) && l1_mask[3]) |=> irq_l1);
    // R9: upper read bits stay zero
    a_r9_upper_zero: assert property (@(posedge clk) disable iff (rst)
        bus_rdata[DATA_W-1:SRC_W] == '0);
endmodule

// File: tb/test_cascade_irq_ctrl.sv
module test_cascade_irq_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  bus_addr = '0;
    logic        bus_wen = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [6:0]  l0_line = '0;
    logic [4:0]  l1_line = '0;
    logic [7:0]  map_line = '0;
    logic [1:0]  tmr_line = '0;
    logic        irq_l0, irq_l1;

    cascade_irq_ctrl i_cascade_irq_ctrl (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wen(bus_wen),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .l0_line(l0_line),
        .l1_line(l1_line), .map_line(map_line), .tmr_line(tmr_line),
        .irq_l0(irq_l0), .irq_l1(irq_l1)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_vec = 0;
    int n_bad = 0;
    bit chk_on = 1'b0;

    // behavioural reference: masks indexed 0=group0,1=group1,2=map0,3=map1
    logic [7:0] m_mask [4];
    logic [1:0] m_flag, m_prev;
    logic       m_irq0, m_irq1;

    function automatic logic [7:0] st0();
        return {|(map_line & m_mask[2]), l0_line};
    endfunction

    function automatic logic [7:0] st1();
        logic [7:0] s;
        s[0] = m_flag[0];
        s[1] = m_flag[1];
        s[2] = l1_line[0];
        s[3] = |(map_line & m_mask[3]);
        s[7:4] = l1_line[4:1];
        return s;
    endfunction

    function automatic logic [31:0] exp_rd(input logic [4:0] a);
        case (a)
            5'h00: return {24'h0, st0()};
            5'h04: return {24'h0, m_mask[0]};
            5'h08: return {24'h0, st1()};
            5'h0C: return {24'h0, m_mask[1]};
            5'h10: return {24'h0, map_line};
            5'h14: return {24'h0, m_mask[2]};
            5'h18: return {24'h0, m_mask[3]};
            default: return 32'h0;
        endcase
    endfunction

    function automatic string tag_of(input logic [4:0] a);
        case (a)
            5'h00: return "R4";
            5'h08: return "R5";
            5'h10: return "R3";
            5'h04, 5'h0C, 5'h14, 5'h18: return "R2";
            default: return "R9";
        endcase
    endfunction

    always @(posedge clk) begin
        logic [1:0] rise, clr;
        logic p0, p1;
        if (rst) begin
            for (int k = 0; k < 4; k++) m_mask[k] = 8'h00;
            m_flag = 2'b00;
            m_prev = tmr_line;
            m_irq0 = 1'b0;
            m_irq1 = 1'b0;
        end else begin
            p0 = |(st0() & m_mask[0]);
            p1 = |(st1() & m_mask[1]);
            rise = tmr_line & ~m_prev;
            clr = (bus_wen && bus_addr == 5'h1C) ? bus_wdata[1:0] : 2'b00;
            m_flag = (m_flag & ~clr) | rise;
            m_prev = tmr_line;
            m_irq0 = p0;
            m_irq1 = p1;
            if (bus_wen) begin
                case (bus_addr)
                    5'h04: m_mask[0] = bus_wdata;
                    5'h0C: m_mask[1] = bus_wdata;
                    5'h14: m_mask[2] = bus_wdata;
                    5'h18: m_mask[3] = bus_wdata;
                    default: ;
                endcase
            end
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // R6 and read path compared against the model on every clock
    always @(negedge clk) begin
        if (chk_on) begin
            check("R6 irq_l0", {31'h0, irq_l0}, {31'h0, m_irq0});
            check("R6 irq_l1", {31'h0, irq_l1}, {31'h0, m_irq1});
            check(tag_of(bus_addr), bus_rdata, exp_rd(bus_addr));
        end
    end

    // drive one cycle of stimulus after the falling edge
    task automatic cyc(input logic [4:0] a, input logic we, input logic [7:0] d);
        @(negedge clk);
        #1;
        bus_addr = a;
        bus_wen = we;
        bus_wdata = d;
    endtask

    task automatic peek(input string tag, input logic [4:0] a, input logic [31:0] exp);
        cyc(a, 1'b0, 8'h00);
        #1;
        check(tag, bus_rdata, exp);
    endtask

    initial begin
        int cnt = 0;
        while (cnt < WATCHDOG) begin
            @(posedge clk);
            cnt++;
        end
        n_bad++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", cnt);
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] lf = 32'h1ACE_B00F;
        tmr_line = 2'b01;                 // high through reset: R1 no flag
        repeat (3) @(posedge clk);
        @(negedge clk); #1; rst = 1'b0;
        @(negedge clk); #1;
        chk_on = 1'b1;
        // R1 reset state
        peek("R1 l0 mask", 5'h04, 32'h0);
        peek("R1 map mask1", 5'h18, 32'h0);
        peek("R1 timer flag0 not set", 5'h08, 32'h0);
        check("R1 irq_l0", {31'h0, irq_l0}, 32'h0);
        // R2 / R9 mask write and read back, map mask1 one word above mask0
        cyc(5'h04, 1'b1, 8'hA5);
        cyc(5'h0C, 1'b1, 8'h3C);
        cyc(5'h14, 1'b1, 8'h0F);
        cyc(5'h18, 1'b1, 8'hF0);
        peek("R2 l0 mask", 5'h04, 32'hA5);
        peek("R9 map mask1 at 0x18", 5'h18, 32'hF0);
        peek("R9 map mask0 at 0x14", 5'h14, 32'h0F);
        // R3 writes to status and clear addresses change no mask
        cyc(5'h00, 1'b1, 8'hFF);
        cyc(5'h10, 1'b1, 8'hFF);
        peek("R3 l0 mask untouched", 5'h04, 32'hA5);
        peek("R9 timer clear reads zero", 5'h1C, 32'h0);
        // R6 local line drives request
        cyc(5'h00, 1'b1, 8'h00);
        l0_line = 7'h01;
        cyc(5'h00, 1'b0, 8'h00);
        @(negedge clk); #1;
        check("R6 irq_l0 raised", {31'h0, irq_l0}, 32'h1);
        l0_line = 7'h02;                  // unmasked bit
        cyc(5'h00, 1'b0, 8'h00);
        @(negedge clk); #1;
        check("R6 irq_l0 dropped", {31'h0, irq_l0}, 32'h0);
        // R4 cascade into group-0 bit 7
        cyc(5'h04, 1'b1, 8'h80);
        map_line = 8'h04;
        cyc(5'h00, 1'b0, 8'h00);
        #1; check("R4 casc0 bit7", bus_rdata, 32'h82);
        @(negedge clk); #1;
        check("R4 irq via cascade", {31'h0, irq_l0}, 32'h1);
        // R5 cascade into group-1 bit 3
        cyc(5'h0C, 1'b1, 8'h08);
        map_line = 8'h40;
        peek("R5 casc1 bit3", 5'h08, 32'h08);
        @(negedge clk); #1;
        check("R5 irq via cascade", {31'h0, irq_l1}, 32'h1);
        map_line = 8'h00;
        // R7 timer edges
        cyc(5'h1C, 1'b1, 8'h03);
        tmr_line = 2'b00;
        cyc(5'h08, 1'b0, 8'h00);
        tmr_line = 2'b11;
        cyc(5'h08, 1'b0, 8'h00);
        #1; check("R7 flags set", bus_rdata, 32'h03);
        // R8 clear flag0 only, line still high: stays clear
        cyc(5'h1C, 1'b1, 8'h01);
        peek("R8 clear bit0 only", 5'h08, 32'h02);
        peek("R7 high level no reset", 5'h08, 32'h02);
        // R8 edge beats clear in same cycle
        tmr_line = 2'b00;
        cyc(5'h08, 1'b0, 8'h00);
        cyc(5'h1C, 1'b1, 8'h03);
        tmr_line = 2'b01;
        peek("R8 edge wins over clear", 5'h08, 32'h01);
        // mixed stimulus compared by the model every clock
        for (int i = 0; i < 600; i++) begin
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            l0_line = lf[6:0];
            l1_line = lf[11:7];
            map_line = lf[19:12];
            tmr_line = lf[21:20];
            cyc({lf[24:22], (lf[25] & lf[26]) ? 2'b10 : 2'b00}, lf[27] & lf[28], lf[31:24]);
        end
        cyc(5'h00, 1'b0, 8'h00);
        @(negedge clk); #1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule